// File: doc/BRIEF.md
# Split Instruction/Data Software-Loaded TLB

This block is a set-associative translation lookaside buffer that keeps two separate halves in one entry array: one for instruction fetches and one for data loads and stores. Software fills entries through a write port. Each entry holds two 32-bit page-table words and the effective page number the entry maps. On a lookup the block takes the effective page number, the access kind, a compare tag (segment identifier and page index bits in page-table layout), a protection key and a no-execute flag. It answers one cycle later with hit, violation, real page number and the rights granted.

Every way of the selected set is searched in order. An entry that matches and allows the access ends the search. An entry that matches but refuses the access is remembered, and the search goes on. When an entry is selected, its referenced flag is written back into the entry. Its changed flag is written back only for a store that was allowed. When the changed flag is still clear and the access is not an allowed store, the write right is withheld from the answer, so the first write to a clean page traps. A read port returns the second word of any entry, so software can see the flags that were written back.

Top module: `sw_tlb_split`

## Requirements
- R1: After synchronous active-low reset, every entry is invalid, `rsp_valid` is low, and any lookup misses.
- R2: The set is the effective page number modulo `SETS`. Data accesses probe entry `way*SETS + set`. Fetches (`req_acc` = 2) probe entry `SETS*WAYS + way*SETS + set`. The write and read ports use this same flat index.
- R3: An entry matches only if all of these hold: bit 31 of word 0 (valid) was 1 when the entry was written; bit 6 of word 0 is 0; word 0 and the request tag are equal under mask 0x7FFFFFBF; the stored effective page number equals the request's.
- R4: Rights come from the key and from PP, which is bits 1:0 of word 1. With key 0, PP 0, 1 and 2 give read+write and PP 3 gives read only. With key 1, PP 0 gives nothing, PP 1 and 3 give read only, and PP 2 gives read+write. `rsp_perm` is {read, write, execute}.
- R5: Execute is granted wherever read is, unless `req_nx` is set. A load (`req_acc` = 0, or the unused code 3) needs read, a store (1) needs write and a fetch (2) needs execute. A refused access sets `rsp_viol`.
- R6: Ways are searched from way 0 upward. The first way that matches and allows the access is selected. If no way allows it, the highest-numbered matching way is selected and reported as a violation.
- R7: The selected entry gets its referenced flag (bit 8 of word 1) set, whether the access was allowed or refused.
- R8: The changed flag (bit 7 of word 1) is set only by an allowed store. When it is clear, every other selected access returns its rights with write removed.
- R9: On a miss, `rsp_hit`, `rsp_viol`, `rsp_rpn` and `rsp_perm` are zero and no entry is altered.
- R10: The response appears on the clock edge after `req_valid`. `rsp_rpn` is bits 31:12 of word 1 of the selected entry. `rd_w1` shows word 1 of entry `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_acc | input | 2 | 0 load, 1 store, 2 fetch (3 acts as load) |
| req_epage | input | ADDR_W-PAGE_BITS | Effective page number |
| req_tag | input | 32 | Compare tag in page-table word 0 layout |
| req_key | input | 1 | Protection key |
| req_nx | input | 1 | No-execute segment flag |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | An entry was selected |
| rsp_viol | output | 1 | Selected entry refused the access |
| rsp_rpn | output | 32-PAGE_BITS | Real page number |
| rsp_perm | output | 3 | Granted rights {read, write, execute} |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Flat entry index |
| wr_w0 | input | 32 | Page-table word 0 |
| wr_w1 | input | 32 | Page-table word 1 |
| wr_epn | input | ADDR_W-PAGE_BITS | Effective page number of the entry |
| rd_idx | input | IDX_W | Read index |
| rd_w1 | output | 32 | Word 1 of entry `rd_idx` |

## Verification
The bench builds the block with four sets and two ways, which gives a 16-entry array. With only eight distinct pages, the stimulus makes two pages compete for every set. Both ways of a set can then hold matching entries with different rights, so the search-order and last-violator rules are reached often. The small array also lets random loads overwrite entries whose flags were just written back. A random read index then returns those flags within a few cycles.

// File: rtl/swtlb_pkg.sv
// Shared types and the protection-table function for the split TLB.
// Assumes 32-bit page-table words with fixed flag positions.
package swtlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // rights vector: [2] read, [1] write, [0] execute
    typedef logic [2:0] perm_t;

    localparam logic [31:0] CMP_MASK = 32'h7FFF_FFBF;
    localparam int          VLD_BIT  = 31;
    localparam int          HSEL_BIT = 6;
    localparam int          REF_BIT  = 8;
    localparam int          CHG_BIT  = 7;

    // Rights from key, PP and no-execute
    function automatic perm_t pp_rights(input logic key, input logic [1:0] pp,
                                        input logic nx);
        logic rd;
        logic wr;
        if (key) begin
            rd = (pp != 2'd0);
            wr = (pp == 2'd2);
        end else begin
            rd = 1'b1;
            wr = (pp != 2'd3);
        end
        return {rd, wr, rd & ~nx};
    endfunction

endpackage

// File: rtl/swtlb_store.sv
// Entry array of the split TLB with one software write port, one R/C
// write-back port, WAYS lookup read ports and one word-1 read port.
// Assumes the write port wins when it targets the write-back entry.
module swtlb_store #(
    parameter int SETS  = 16,
    parameter int WAYS  = 2,
    parameter int EPN_W = 20,
    parameter int RPN_W = 20,
    localparam int N     = 2 * SETS * WAYS,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [31:0]                      wr_w0,
    input  logic [31:0]                      wr_w1,
    input  logic [EPN_W-1:0]                 wr_epn,
    input  logic                             upd_en,
    input  logic [IDX_W-1:0]                 upd_idx,
    input  logic                             upd_set_r,
    input  logic                             upd_set_c,
    input  logic [WAYS-1:0][IDX_W-1:0]       lk_idx,
    output logic [WAYS-1:0][31:0]            lk_w0,
    output logic [WAYS-1:0][EPN_W-1:0]       lk_epn,
    output logic [WAYS-1:0][RPN_W-1:0]       lk_rpn,
    output logic [WAYS-1:0][1:0]             lk_pp,
    output logic [WAYS-1:0]                  lk_ref,
    output logic [WAYS-1:0]                  lk_chg,
    input  logic [IDX_W-1:0]                 rd_idx,
    output logic [31:0]                      rd_w1
);
    import swtlb_pkg::*;

    logic [N-1:0]       vld_q;
    logic [30:0]        w0_q  [N];
    logic [31:0]        w1_q  [N];
    logic [EPN_W-1:0]   epn_q [N];

    logic wr_collide;
    assign wr_collide = wr_en && (wr_idx == upd_idx);

    // Valid bits: cleared by reset, loaded from word 0 bit 31
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= wr_w0[VLD_BIT];
        end
    end

    // Entry payload: software load, then flag write-back elsewhere
    always_ff @(posedge clk) begin
        if (wr_en) begin
            w0_q[wr_idx]  <= wr_w0[30:0];
            w1_q[wr_idx]  <= wr_w1;
            epn_q[wr_idx] <= wr_epn;
        end
        if (rst_n && upd_en && !wr_collide) begin
            if (upd_set_r) w1_q[upd_idx][REF_BIT] <= 1'b1;
            if (upd_set_c) w1_q[upd_idx][CHG_BIT] <= 1'b1;
        end
    end

    // Lookup reads, one per way, valid folded into bit 31
    always_comb begin
        for (int g = 0; g < WAYS; g++) begin
            lk_w0[g]  = {vld_q[lk_idx[g]], w0_q[lk_idx[g]]};
            lk_epn[g] = epn_q[lk_idx[g]];
            lk_rpn[g] = w1_q[lk_idx[g]][31 -: RPN_W];
            lk_pp[g]  = w1_q[lk_idx[g]][1:0];
            lk_ref[g] = w1_q[lk_idx[g]][REF_BIT];
            lk_chg[g] = w1_q[lk_idx[g]][CHG_BIT];
        end
    end

    // Software read of word 1
    assign rd_w1 = w1_q[rd_idx];

    p_ref_written_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_set_r && !wr_collide) |=> w1_q[$past(upd_idx)][REF_BIT]);

    p_chg_written_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_set_c && !wr_collide) |=> w1_q[$past(upd_idx)][CHG_BIT]);

endmodule

// File: rtl/swtlb_way_eval.sv
// Per-way match and rights evaluation for one probed entry.
// Assumes word 0 arrives with the stored valid bit in bit 31.
module swtlb_way_eval #(
    parameter int EPN_W = 20
) (
    input  logic [31:0]        ent_w0,
    input  logic [EPN_W-1:0]   ent_epn,
    input  logic [1:0]         ent_pp,
    input  logic [EPN_W-1:0]   req_epn,
    input  logic [31:0]        req_tag,
    input  logic               req_key,
    input  logic               req_nx,
    input  swtlb_pkg::acc_e    req_acc,
    output logic               hit,
    output logic               ok,
    output swtlb_pkg::perm_t   perm
);
    import swtlb_pkg::*;

    // Match: page, valid, primary hash, compare field
    always_comb begin
        hit = ent_w0[VLD_BIT] && !ent_w0[HSEL_BIT] && (ent_epn == req_epn)
              && ((ent_w0 & CMP_MASK) == (req_tag & CMP_MASK));
    end

    // Rights and the right this access needs
    always_comb begin
        perm = pp_rights(req_key, ent_pp, req_nx);
        case (req_acc)
            ACC_STORE: ok = perm[1];
            ACC_FETCH: ok = perm[0];
            default:   ok = perm[2];
        endcase
    end

endmodule

// File: rtl/swtlb_select.sv
// Ordered way selection: first allowing match wins, otherwise the
// last refusing match is kept. Assumes WAYS fits in WAY_W bits.
module swtlb_select #(
    parameter int WAYS = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  way_hit,
    input  logic [WAYS-1:0]  way_ok,
    output logic             sel_any,
    output logic             sel_ok,
    output logic [WAY_W-1:0] sel_way
);
    // Priority scan over ways in ascending order
    always_comb begin
        sel_any = 1'b0;
        sel_ok  = 1'b0;
        sel_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!sel_ok && way_hit[w]) begin
                sel_any = 1'b1;
                sel_way = WAY_W'(w);
                sel_ok  = way_ok[w];
            end
        end
    end
endmodule

// File: rtl/sw_tlb_split.sv
// Top of the split instruction/data software-loaded TLB. Computes the
// per-way entry indices, selects the entry, trims rights for clean pages,
// drives the flag write-back and registers the response.
// Assumes SETS is a power of two and at least 2.
module sw_tlb_split #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int SETS      = 16,
    parameter int WAYS      = 2,
    localparam int EPN_W  = ADDR_W - PAGE_BITS,
    localparam int RPN_W  = 32 - PAGE_BITS,
    localparam int HALF_N = SETS * WAYS,
    localparam int IDX_W  = $clog2(2 * HALF_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_acc,
    input  logic [EPN_W-1:0]   req_epage,
    input  logic [31:0]        req_tag,
    input  logic               req_key,
    input  logic               req_nx,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_viol,
    output logic [RPN_W-1:0]   rsp_rpn,
    output logic [2:0]         rsp_perm,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [31:0]        wr_w0,
    input  logic [31:0]        wr_w1,
    input  logic [EPN_W-1:0]   wr_epn,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [31:0]        rd_w1
);
    import swtlb_pkg::*;

    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    acc_e                          acc;
    logic                          is_fetch;
    logic [SET_W-1:0]              set_idx;
    logic [WAYS-1:0][IDX_W-1:0]    lk_idx;
    logic [WAYS-1:0][31:0]         lk_w0;
    logic [WAYS-1:0][EPN_W-1:0]    lk_epn;
    logic [WAYS-1:0][RPN_W-1:0]    lk_rpn;
    logic [WAYS-1:0][1:0]          lk_pp;
    logic [WAYS-1:0]               lk_ref;
    logic [WAYS-1:0]               lk_chg;
    logic [WAYS-1:0]               way_hit;
    logic [WAYS-1:0]               way_ok;
    perm_t [WAYS-1:0]              way_perm;
    logic                          sel_any;
    logic                          sel_ok;
    logic [WAY_W-1:0]              sel_way;
    logic                          strip_w;
    perm_t                         fin_perm;
    logic                          upd_en;
    logic                          upd_set_r;
    logic                          upd_set_c;
    acc_e                          acc_q;

    assign acc      = acc_e'(req_acc);
    assign is_fetch = (acc == ACC_FETCH);
    assign set_idx  = req_epage[SET_W-1:0];

    // One probe index per way into the half chosen by the access kind
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign lk_idx[g] = IDX_W'((is_fetch ? HALF_N : 0) + g * SETS + int'(set_idx));

        swtlb_way_eval #(.EPN_W(EPN_W)) u_eval (
            .ent_w0  (lk_w0[g]),
            .ent_epn (lk_epn[g]),
            .ent_pp  (lk_pp[g]),
            .req_epn (req_epage),
            .req_tag (req_tag),
            .req_key (req_key),
            .req_nx  (req_nx),
            .req_acc (acc),
            .hit     (way_hit[g]),
            .ok      (way_ok[g]),
            .perm    (way_perm[g])
        );
    end

    swtlb_select #(.WAYS(WAYS)) u_sel (
        .way_hit (way_hit),
        .way_ok  (way_ok),
        .sel_any (sel_any),
        .sel_ok  (sel_ok),
        .sel_way (sel_way)
    );

    // Clean-page rule: withhold write unless this is an allowed store
    always_comb begin
        strip_w   = !lk_chg[sel_way] && !((acc == ACC_STORE) && sel_ok);
        fin_perm  = way_perm[sel_way] & ~{1'b0, strip_w, 1'b0};
        upd_en    = req_valid && sel_any;
        upd_set_r = !lk_ref[sel_way];
        upd_set_c = !lk_chg[sel_way] && (acc == ACC_STORE) && sel_ok;
    end

    swtlb_store #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .EPN_W (EPN_W),
        .RPN_W (RPN_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_w0     (wr_w0),
        .wr_w1     (wr_w1),
        .wr_epn    (wr_epn),
        .upd_en    (upd_en),
        .upd_idx   (lk_idx[sel_way]),
        .upd_set_r (upd_set_r),
        .upd_set_c (upd_set_c),
        .lk_idx    (lk_idx),
        .lk_w0     (lk_w0),
        .lk_epn    (lk_epn),
        .lk_rpn    (lk_rpn),
        .lk_pp     (lk_pp),
        .lk_ref    (lk_ref),
        .lk_chg    (lk_chg),
        .rd_idx    (rd_idx),
        .rd_w1     (rd_w1)
    );

    // Response register, cleared when no request is present
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_viol  <= 1'b0;
            rsp_rpn   <= '0;
            rsp_perm  <= '0;
            acc_q     <= ACC_LOAD;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && sel_any;
            rsp_viol  <= req_valid && sel_any && !sel_ok;
            rsp_rpn   <= (req_valid && sel_any) ? lk_rpn[sel_way] : '0;
            rsp_perm  <= (req_valid && sel_any) ? fin_perm : '0;
            acc_q     <= acc;
        end
    end

    p_rsp_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_perm == 3'b000 && !rsp_viol && rsp_rpn == '0));

    p_viol_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_viol |-> rsp_hit);

    p_granted_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && !rsp_viol) |->
        ((acc_q == ACC_STORE) ? rsp_perm[1] :
         (acc_q == ACC_FETCH) ? rsp_perm[0] : rsp_perm[2]));

    p_write_only_when_readable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_perm[1] |-> rsp_perm[2]);

endmodule

// File: tb/sw_tlb_split_tb_top.sv
`timescale 1ns/1ps
module sw_tlb_split_tb_top;

    localparam int ADDR_W = 32;
    localparam int PB     = 12;
    localparam int SETS   = 4;
    localparam int WAYS   = 2;
    localparam int N      = 2 * SETS * WAYS;
    localparam int IDX_W  = $clog2(N);
    localparam logic [31:0] MASK = 32'h7FFF_FFBF;
    localparam logic [31:0] T0 = 32'h0012_3401;
    localparam logic [31:0] T1 = 32'h0045_6702;
    localparam logic [31:0] T2 = 32'h00AB_CD05;
    localparam logic [31:0] T3 = 32'h0000_0080;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_acc = '0;
    logic [19:0] req_epage = '0;
    logic [31:0] req_tag = '0;
    logic req_key = 1'b0;
    logic req_nx = 1'b0;
    logic rsp_valid, rsp_hit, rsp_viol;
    logic [19:0] rsp_rpn;
    logic [2:0] rsp_perm;
    logic wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [31:0] wr_w0 = '0;
    logic [31:0] wr_w1 = '0;
    logic [19:0] wr_epn = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [31:0] rd_w1;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic        m_vld [N];
    logic [31:0] m_w0  [N];
    logic [31:0] m_w1  [N];
    logic [19:0] m_epn [N];

    always #4 clk = ~clk;

    sw_tlb_split #(.ADDR_W(ADDR_W), .PAGE_BITS(PB), .SETS(SETS), .WAYS(WAYS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_acc(req_acc),
        .req_epage(req_epage), .req_tag(req_tag), .req_key(req_key), .req_nx(req_nx),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_viol(rsp_viol),
        .rsp_rpn(rsp_rpn), .rsp_perm(rsp_perm), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_w0(wr_w0), .wr_w1(wr_w1), .wr_epn(wr_epn), .rd_idx(rd_idx), .rd_w1(rd_w1)
    );

    function automatic logic [31:0] mk_w1(logic [19:0] rpn, logic r, logic c, logic [1:0] pp);
        return {rpn, 3'b000, r, c, 5'b00000, pp};
    endfunction

    function automatic logic [2:0] rights(logic key, logic [1:0] pp, logic nx);
        logic r, w;
        r = key ? (pp != 2'd0) : 1'b1;
        w = key ? (pp == 2'd2) : (pp != 2'd3);
        return {r, w, r & ~nx};
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    endtask

    task automatic write_ent(input int idx, input logic [31:0] w0, input logic [31:0] w1,
                             input logic [19:0] epn);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_w0 = w0; wr_w1 = w1; wr_epn = epn;
        @(negedge clk);
        wr_en = 1'b0;
        m_vld[idx] = w0[31]; m_w0[idx] = w0; m_w1[idx] = w1; m_epn[idx] = epn;
    endtask

    // Drive one lookup; result is sampled at the next falling edge
    task automatic lookup(input logic [1:0] acc, input logic [19:0] ep, input logic [31:0] tag,
                          input logic key, input logic nx, output logic [25:0] res);
        @(negedge clk);
        req_valid = 1'b1; req_acc = acc; req_epage = ep; req_tag = tag;
        req_key = key; req_nx = nx;
        @(negedge clk);
        req_valid = 1'b0;
        res = {rsp_valid, rsp_hit, rsp_viol, rsp_rpn, rsp_perm};
    endtask

    task automatic readback(input int idx, output logic [31:0] v);
        rd_idx = IDX_W'(idx);
        #1;
        v = rd_w1;
    endtask

    // Reference model built from the requirements; updates the mirror
    task automatic model(input logic [1:0] acc, input logic [19:0] ep, input logic [31:0] tag,
                         input logic key, input logic nx, output logic [25:0] res);
        int sel;
        logic granted;
        logic [2:0] p, psel;
        sel = -1; granted = 1'b0; psel = '0;
        for (int w = 0; w < WAYS; w++) begin
            int idx;
            idx = ((acc == 2'd2) ? SETS * WAYS : 0) + w * SETS + int'(ep % SETS);
            if (m_vld[idx] && !m_w0[idx][6] && m_epn[idx] == ep &&
                ((m_w0[idx] & MASK) == (tag & MASK))) begin
                logic need;
                p = rights(key, m_w1[idx][1:0], nx);
                need = (acc == 2'd1) ? p[1] : (acc == 2'd2) ? p[0] : p[2];
                sel = idx; psel = p;
                if (need) begin
                    granted = 1'b1;
                    break;
                end
            end
        end
        if (sel < 0) begin
            res = {1'b1, 1'b0, 1'b0, 20'h0, 3'b000};
        end else begin
            if (!m_w1[sel][7] && !(acc == 2'd1 && granted)) psel[1] = 1'b0;
            res = {1'b1, 1'b1, !granted, m_w1[sel][31:12], psel};
            m_w1[sel][8] = 1'b1;
            if (acc == 2'd1 && granted) m_w1[sel][7] = 1'b1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [25:0] r, e;
        logic [31:0] v;
        logic [31:0] pool [4];
        pool[0] = T0; pool[1] = T1; pool[2] = T2; pool[3] = T3;
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0; m_w0[i] = '0; m_w1[i] = '0; m_epn[i] = '0;
        end
        do_reset();

        // R1: reset state and empty array
        chk("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        lookup(2'd0, 20'd1, T0, 1'b0, 1'b0, r);
        chk("R1 lookup misses after reset", r, {1'b1, 25'd0});

        // R2: data half hit, fetch half miss
        write_ent(1, 32'h8000_0000 | T0, mk_w1(20'hABCDE, 1, 1, 2'd2), 20'd1);
        lookup(2'd0, 20'd1, T0, 1'b1, 1'b0, r);
        chk("R2 data entry hit", r, {3'b110, 20'hABCDE, 3'b111});
        lookup(2'd2, 20'd1, T0, 1'b1, 1'b0, r);
        chk("R2 fetch misses data entry", r, {1'b1, 25'd0});

        // R3: hash-select bit, page mismatch, tag mismatch
        write_ent(1, 32'h8000_0040 | T0, mk_w1(20'hABCDE, 1, 1, 2'd2), 20'd1);
        lookup(2'd0, 20'd1, T0, 1'b0, 1'b0, r);
        chk("R3 hash-select set misses", r, {1'b1, 25'd0});
        write_ent(1, 32'h8000_0000 | T0, mk_w1(20'hABCDE, 1, 1, 2'd2), 20'd1);
        lookup(2'd0, 20'd5, T0, 1'b0, 1'b0, r);
        chk("R3 page mismatch misses", r, {1'b1, 25'd0});
        lookup(2'd0, 20'd1, T2, 1'b0, 1'b0, r);
        chk("R3 tag mismatch misses", r, {1'b1, 25'd0});
        lookup(2'd0, 20'd1, T0 | 32'h8000_0040, 1'b0, 1'b0, r);
        chk("R3 masked request bits ignored", r, {3'b110, 20'hABCDE, 3'b111});

        // R4: protection table with flags already set
        for (int k = 0; k < 2; k++) begin
            for (int pp = 0; pp < 4; pp++) begin
                logic [2:0] ep;
                logic vv;
                write_ent(1, 32'h8000_0000 | T0, mk_w1(20'hABCDE, 1, 1, 2'(pp)), 20'd1);
                lookup(2'd0, 20'd1, T0, 1'(k), 1'b0, r);
                if (k == 0) ep = (pp == 3) ? 3'b101 : 3'b111;
                else ep = (pp == 0) ? 3'b000 : (pp == 2) ? 3'b111 : 3'b101;
                vv = (ep == 3'b000);
                chk($sformatf("R4 key%0d pp%0d", k, pp), r, {2'b11, vv, 20'hABCDE, ep});
            end
        end

        // R5: no-execute on fetch half, store needs write
        write_ent(9, 32'h8000_0000 | T0, mk_w1(20'h0F0F0, 1, 1, 2'd2), 20'd1);
        lookup(2'd2, 20'd1, T0, 1'b0, 1'b1, r);
        chk("R5 fetch with nx refused", r, {3'b111, 20'h0F0F0, 3'b110});
        lookup(2'd2, 20'd1, T0, 1'b0, 1'b0, r);
        chk("R5 fetch without nx allowed", r, {3'b110, 20'h0F0F0, 3'b111});
        write_ent(1, 32'h8000_0000 | T0, mk_w1(20'hABCDE, 1, 1, 2'd1), 20'd1);
        lookup(2'd1, 20'd1, T0, 1'b1, 1'b0, r);
        chk("R5 store on read-only refused", r, {3'b111, 20'hABCDE, 3'b101});

        // R6: search order across ways
        write_ent(2, 32'h8000_0000 | T1, mk_w1(20'h11111, 1, 1, 2'd0), 20'd2);
        write_ent(6, 32'h8000_0000 | T1, mk_w1(20'h22222, 1, 1, 2'd2), 20'd2);
        lookup(2'd0, 20'd2, T1, 1'b1, 1'b0, r);
        chk("R6 later allowing way wins over refusing way", r, {3'b110, 20'h22222, 3'b111});
        write_ent(6, 32'h8000_0000 | T1, mk_w1(20'h22222, 1, 1, 2'd0), 20'd2);
        lookup(2'd0, 20'd2, T1, 1'b1, 1'b0, r);
        chk("R6 last refusing way reported", r, {3'b111, 20'h22222, 3'b000});
        write_ent(2, 32'h8000_0000 | T1, mk_w1(20'h11111, 1, 1, 2'd2), 20'd2);
        write_ent(6, 32'h8000_0000 | T1, mk_w1(20'h22222, 1, 1, 2'd2), 20'd2);
        lookup(2'd0, 20'd2, T1, 1'b1, 1'b0, r);
        chk("R6 first allowing way wins", r, {3'b110, 20'h11111, 3'b111});

        // R7: referenced flag on a refused access
        write_ent(3, 32'h8000_0000 | T2, mk_w1(20'h33333, 0, 0, 2'd0), 20'd3);
        lookup(2'd0, 20'd3, T2, 1'b1, 1'b0, r);
        chk("R7 refused lookup result", r, {3'b111, 20'h33333, 3'b000});
        readback(3, v);
        chk("R7 referenced set on refusal", v, 32'h3333_3100);

        // R8: changed flag rules
        write_ent(3, 32'h8000_0000 | T2, mk_w1(20'h33333, 0, 0, 2'd2), 20'd3);
        lookup(2'd0, 20'd3, T2, 1'b0, 1'b0, r);
        chk("R8 clean page load loses write", r, {3'b110, 20'h33333, 3'b101});
        readback(3, v);
        chk("R8 load leaves changed clear", v, 32'h3333_3102);
        lookup(2'd1, 20'd3, T2, 1'b0, 1'b0, r);
        chk("R8 allowed store", r, {3'b110, 20'h33333, 3'b111});
        readback(3, v);
        chk("R8 store sets changed", v, 32'h3333_3182);
        lookup(2'd0, 20'd3, T2, 1'b0, 1'b0, r);
        chk("R8 dirty page load keeps write", r, {3'b110, 20'h33333, 3'b111});
        write_ent(3, 32'h8000_0000 | T2, mk_w1(20'h33333, 0, 0, 2'd3), 20'd3);
        lookup(2'd1, 20'd3, T2, 1'b0, 1'b0, r);
        chk("R8 refused store", r, {3'b111, 20'h33333, 3'b101});
        readback(3, v);
        chk("R8 refused store leaves changed clear", v, 32'h3333_3103);

        // R9: miss leaves entries untouched
        write_ent(3, 32'h8000_0000 | T2, mk_w1(20'h33333, 0, 0, 2'd2), 20'd3);
        lookup(2'd1, 20'd3, T3, 1'b0, 1'b0, r);
        chk("R9 miss result zero", r, {1'b1, 25'd0});
        readback(3, v);
        chk("R9 miss leaves flags", v, 32'h3333_3002);

        // R1: reset invalidates loaded entries
        do_reset();
        lookup(2'd0, 20'd2, T1, 1'b1, 1'b0, r);
        chk("R1 reset invalidates", r, {1'b1, 25'd0});

        // Random mix against the model (R2..R10)
        void'($urandom(32'd2024));
        for (int it = 0; it < 600; it++) begin
            if ($urandom_range(0, 2) == 0) begin
                int half, way, ep;
                logic [31:0] w0;
                half = $urandom_range(0, 1);
                way  = $urandom_range(0, WAYS - 1);
                ep   = $urandom_range(0, 7);
                w0 = pool[$urandom_range(0, 3)];
                if ($urandom_range(0, 7) != 0) w0[31] = 1'b1;
                if ($urandom_range(0, 7) == 0) w0[6] = 1'b1;
                write_ent(half * SETS * WAYS + way * SETS + (ep % SETS), w0,
                          mk_w1(20'($urandom), 1'($urandom), 1'($urandom), 2'($urandom)),
                          20'(ep));
            end
            begin
                logic [1:0] acc;
                logic [19:0] ep;
                logic [31:0] tg;
                logic key, nx;
                acc = 2'($urandom_range(0, 3));
                ep  = 20'($urandom_range(0, 7));
                tg  = pool[$urandom_range(0, 3)];
                key = 1'($urandom);
                nx  = 1'($urandom);
                model(acc, ep, tg, key, nx, e);
                lookup(acc, ep, tg, key, nx, r);
                chk("R10 random lookup vs model (R4 R5 R6 R8)", r, e);
            end
            begin
                int ri;
                ri = $urandom_range(0, N - 1);
                readback(ri, v);
                if (m_vld[ri]) chk("R7 random flag readback", v, m_w1[ri]);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule